// File: doc/BRIEF.md
# Repeated-Subtraction Integer Divider

This unit divides a positive 8-bit dividend by a positive 8-bit divisor by counting subtractions. After it accepts a start request, it loads the dividend into a working remainder. In each clock cycle it compares that remainder against the divisor. When the divisor fits, it subtracts the divisor and adds one to the quotient. When the divisor no longer fits, the unit raises `done_o` for one cycle and returns to idle. The number of cycles a division takes therefore depends on the data.

Both operands must be positive two's-complement values in the range 1 to 127. The unit rejects a zero divisor, a zero dividend or any operand with its top bit set. In that case it raises an error flag and completes immediately, so a bad divisor can never keep it busy forever. The quotient, remainder and error flag stay at their values until the next accepted start.

Top module: `rsub_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `quot_o` and `rem_o` are all 0.
- R2: For valid operands, `quot_o` is the number of subtractions of the divisor that leave the working value non-negative, and `rem_o` is what remains after the last one (A=10, B=3 gives 3 and 1).
- R3: Exactly one compare-and-subtract is performed per clock cycle, so `done_o` rises on the (Q+1)th rising edge after the edge that accepts start, where Q is the quotient.
- R4: When the dividend is smaller than the divisor, the result is quotient 0 and remainder equal to the dividend, with no subtraction, and `done_o` rises on the first edge after acceptance.
- R5: An operand is invalid when it is 0 or has bit 7 set. An invalid operand sets `err_o` to 1, gives quotient 0 and remainder equal to the dividend, and raises `done_o` on the accepting edge itself.
- R6: A start with valid operands clears `err_o` to 0.
- R7: `done_o` stays high for exactly one cycle per division.
- R8: `start_i` is ignored while `busy_o` is high; the running division finishes with its original operands.
- R9: `quot_o`, `rem_o` and `err_o` hold their values from completion until the next accepted start.
- R10: For valid operands, `busy_o` is high from the accepting edge until the edge that raises `done_o`, and `busy_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a division; accepted only while idle |
| dividend_i | input | 8 | Dividend A, sampled on the accepting edge |
| divisor_i | input | 8 | Divisor B, sampled on the accepting edge |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Operand out of range or divisor zero |
| quot_o | output | 8 | Quotient |
| rem_o | output | 8 | Remainder |

## Verification
Several operand pairs test the data-dependent loop. A small divisor against the largest dividend (127/1) gives the longest run. Equal operands stop after exactly one subtraction, and A<B stops with no subtraction at all. Pairs such as 10/3 and 100/7 leave a non-zero remainder, which separates an off-by-one in the stop test from a correct compare. Each of the rejection cases is tried on its own: a zero divisor, a zero dividend and operands with bit 7 set. Directed runs then pulse start in the middle of a long division and check that the results stay put after completion.

// File: rtl/rsub_divider_pkg.sv
package rsub_divider_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/rsub_operand_check.sv
module rsub_operand_check #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              ok_o
);
  localparam int SIGN_BIT = DATA_W - 1;

  logic a_ok, b_ok;

  always_comb begin
    a_ok = (dividend_i != '0) && !dividend_i[SIGN_BIT];
    b_ok = (divisor_i  != '0) && !divisor_i[SIGN_BIT];
    ok_o = a_ok && b_ok;
  end
endmodule

// File: rtl/rsub_ctrl.sv
module rsub_ctrl
  import rsub_divider_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ops_ok_i,
  input  logic borrow_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  div_state_e state_q, state_n;
  logic       done_q, done_n;
  logic       err_q, err_n;
  logic       accept;

  always_comb begin
    accept  = (state_q == ST_IDLE) && start_i;
    state_n = state_q;
    done_n  = 1'b0;
    err_n   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          err_n = !ops_ok_i;
          if (ops_ok_i) state_n = ST_RUN;
          else          done_n  = 1'b1;
        end
      end
      ST_RUN: begin
        if (borrow_i) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign load_o = accept;
  assign step_o = (state_q == ST_RUN) && !borrow_i;
  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
  assign err_o  = err_q;

  // R7: the completion pulse lasts one cycle unless a new request restarts
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> !done_q);

  // R10: running and completing are mutually exclusive
  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_q));

  // R8: a request during a run cannot touch the error flag
  a_r8_err_frozen_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> $stable(err_q));
endmodule

// File: rtl/rsub_datapath.sv
module rsub_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              borrow_o,
  output logic [DATA_W-1:0] quot_o,
  output logic [DATA_W-1:0] rem_o
);
  localparam int DIFF_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] rem_q, rem_n;
  logic [DATA_W-1:0] quot_q, quot_n;
  logic [DATA_W-1:0] div_q, div_n;
  logic [DIFF_W-1:0] diff;

  always_comb begin
    diff   = {1'b0, rem_q} - {1'b0, div_q};
    rem_n  = rem_q;
    quot_n = quot_q;
    div_n  = div_q;
    if (load_i) begin
      rem_n  = dividend_i;
      quot_n = '0;
      div_n  = divisor_i;
    end else if (step_i) begin
      rem_n  = diff[DATA_W-1:0];
      quot_n = quot_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quot_q <= '0;
      div_q  <= '0;
    end else if (load_i || step_i) begin
      rem_q  <= rem_n;
      quot_q <= quot_n;
      div_q  <= div_n;
    end
  end

  assign borrow_o = diff[DATA_W];
  assign quot_o   = quot_q;
  assign rem_o    = rem_q;

  // R3: every successful compare adds exactly one to the quotient
  a_r3_quot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (quot_q == $past(quot_q) + ONE));

  // R2: a successful subtraction strictly lowers the working value
  a_r2_rem_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (rem_q < $past(rem_q)));

  // R9: results hold when neither loading nor stepping
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> ($stable(rem_q) && $stable(quot_q)));
endmodule

// File: rtl/rsub_divider.sv
module rsub_divider #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] quot_o,
  output logic [DATA_W-1:0] rem_o
);
  logic ops_ok, load, step, borrow;

  rsub_operand_check #(.DATA_W(DATA_W)) u_check (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .ok_o       (ops_ok)
  );

  rsub_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ops_ok_i (ops_ok),
    .borrow_i (borrow),
    .load_o   (load),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  rsub_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .step_i     (step),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .borrow_o   (borrow),
    .quot_o     (quot_o),
    .rem_o      (rem_o)
  );

  // R5: an error completion carries a zero quotient
  a_r5_err_zero_quot: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (quot_o == '0));

  // R2: a valid completion leaves a remainder below the divisor
  a_r2_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (rem_o < u_dp.div_q));
endmodule

// File: tb/rsub_divider_tb.sv
module rsub_divider_tb;
  localparam int NV = 13;
  // {A, B, quotient, remainder, err}
  localparam logic [32:0] VEC [NV] = '{
    {8'd10,  8'd3,   8'd3,   8'd1,   1'b0},
    {8'd127, 8'd1,   8'd127, 8'd0,   1'b0},
    {8'd5,   8'd9,   8'd0,   8'd5,   1'b0},
    {8'd7,   8'd7,   8'd1,   8'd0,   1'b0},
    {8'd100, 8'd7,   8'd14,  8'd2,   1'b0},
    {8'd127, 8'd127, 8'd1,   8'd0,   1'b0},
    {8'd1,   8'd1,   8'd1,   8'd0,   1'b0},
    {8'd64,  8'd2,   8'd32,  8'd0,   1'b0},
    {8'd1,   8'd127, 8'd0,   8'd1,   1'b0},
    {8'd9,   8'd0,   8'd0,   8'd9,   1'b1},
    {8'd0,   8'd5,   8'd0,   8'd0,   1'b1},
    {8'd200, 8'd3,   8'd0,   8'd200, 1'b1},
    {8'd50,  8'd130, 8'd0,   8'd50,  1'b1}
  };

  logic       clk, rst_n, start_i;
  logic [7:0] dividend_i, divisor_i;
  logic       busy_o, done_o, err_o;
  logic [7:0] quot_o, rem_o;

  int n_tests = 0;
  int n_fail  = 0;
  int wd      = 0;

  rsub_divider u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .quot_o(quot_o), .rem_o(rem_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse start for one cycle, then wait for done; returns negedges counted
  // (1 = done on the accepting edge, k = done on edge k-1 after accepting edge)
  task automatic launch(input logic [7:0] a, input logic [7:0] b, output int cnt);
    @(negedge clk);
    dividend_i = a; divisor_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 1;
    while (!done_o && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  initial begin
    int cnt;
    start_i = 1'b0; dividend_i = '0; divisor_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 err",  err_o,  0);
    check("R1 quot", quot_o, 0);
    check("R1 rem",  rem_o,  0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] a, b, q, r;
      logic       e;
      {a, b, q, r, e} = VEC[i];
      @(negedge clk);
      dividend_i = a; divisor_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R10 busy right after a valid acceptance; idle after an invalid one
      check("R10 busy after accept", busy_o, e ? 0 : 1);
      cnt = 1;
      while (!done_o && cnt < 400) begin
        @(negedge clk);
        cnt++;
      end
      check("R2/R5 quotient", quot_o, q);
      check("R2/R4/R5 remainder", rem_o, r);
      check("R5/R6 err", err_o, e);
      // R3 / R4 / R5 latency
      check(e ? "R5 latency" : (q == 0 ? "R4 latency" : "R3 latency"),
            cnt, e ? 1 : q + 2);
      check("R10 not busy at done", busy_o, 0);
      @(negedge clk);
      check("R7 done single", done_o, 0);
    end

    // R6: valid start after an error clears the flag
    launch(8'd20, 8'd6, cnt);
    check("R6 err cleared", err_o, 0);
    check("R6 quotient", quot_o, 3);
    check("R6 remainder", rem_o, 2);

    // R9: results hold while idle
    repeat (6) @(negedge clk);
    check("R9 quot hold", quot_o, 3);
    check("R9 rem hold",  rem_o,  2);
    check("R9 err hold",  err_o,  0);
    check("R7 no stray done", done_o, 0);

    // R8: start during a run is ignored
    @(negedge clk);
    dividend_i = 8'd127; divisor_i = 8'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    dividend_i = 8'd9; divisor_i = 8'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; dividend_i = 8'd0; divisor_i = 8'd0;
    cnt = 7;
    while (!done_o && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    check("R8 quotient", quot_o, 127);
    check("R8 remainder", rem_o, 0);
    check("R8 err", err_o, 0);
    check("R8 latency", cnt, 129);

    // R9: error result holds too
    launch(8'd33, 8'd0, cnt);
    repeat (4) @(negedge clk);
    check("R9 err hold", err_o, 1);
    check("R9 rem hold after err", rem_o, 33);

    // R1: asynchronous reset mid-run returns to the reset state
    @(negedge clk);
    dividend_i = 8'd120; divisor_i = 8'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 busy after reset", busy_o, 0);
    check("R1 quot after reset", quot_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule